// File: doc/BRIEF.md
# Bus-Snooping MESI Coherence Controller

This block keeps a small group of private data caches coherent over one shared bus and one backing memory. Each core has a direct-mapped cache whose lines are each tagged with one of four ownership states: Modified, Exclusive, Shared or Invalid. A core load or store that can be served locally finishes in one cycle. Any other access becomes one bus transaction: a plain read, a read-for-ownership, an invalidate-only upgrade, or a write-back of a dirty victim. All other caches watch each transaction, answer it, and downgrade or drop their own copies.

A round-robin arbiter lets one transaction onto the bus at a time. The bus sequencer runs a snoop phase, then (for data fills) a memory phase, then signals completion to the requester. A dirty copy found in the snoop phase is written to memory before the memory read, so the requester always fills with the latest line. A probe port gives each cache's state for one chosen line, one cycle after the line address is presented.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: Line states are encoded on `prb_state` as Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11, two bits per core with core k at bits [2k+1:2k]. After reset every line of every cache reads Invalid.
- R2: A load miss fills the line in Exclusive when no other cache holds it, and in Shared when any other cache holds it.
- R3: A store to a line held in Exclusive or Modified raises `resp_done` in the cycle after the request is taken, with no bus transaction, and leaves the line Modified.
- R4: A store to a line held in Shared takes more than one cycle, because it first broadcasts an invalidation. It ends with the writer in Modified and every other copy in Invalid.
- R5: A store miss issues a read-for-ownership. A remote Modified copy is flushed and goes Invalid, and the requester ends in Modified with the flushed line merged with its new word.
- R6: A plain read snooped by a cache holding the line in Modified writes the dirty line to memory before the requester fills. Both copies end in Shared, and the requester reads the dirty data.
- R7: A load returns the most recently stored value of that word address in any core. A word never stored reads as its own word address modulo 2^WORD_W.
- R8: Ownership is tracked per line (2^OFF_BITS words). A store to one word invalidates other caches' copies that were filled through a different word of the same line.
- R9: At no cycle does more than one cache hold a line in Modified or Exclusive. While one cache does, all other caches hold that line Invalid.
- R10: A fill that displaces a Modified line writes it back first, so its data is still readable from another core. A displaced clean line is dropped. A displaced line reads Invalid in that cache.
- R11: Only one bus transaction is in flight at a time, and requests are granted round-robin. Simultaneous requests from all cores each complete with correct data.
- R12: A snooped plain read turns a remote Exclusive copy into Shared. A snooped read-for-ownership or invalidate turns a remote Exclusive or Shared copy into Invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORES | Per-core request, held high until `resp_done` |
| req_write | input | NCORES | Per-core request is a store |
| req_addr | input | NCORES*AW | Per-core word address {tag, set, word} |
| req_wdata | input | NCORES*WORD_W | Per-core store data |
| resp_done | output | NCORES | One-cycle completion pulse per core |
| resp_rdata | output | NCORES*WORD_W | Load data, valid with `resp_done` |
| prb_addr | input | TAG_BITS+SET_BITS | Line address to probe |
| prb_state | output | 2*NCORES | Registered state of the probed line in each cache |

## Verification
The assertions assume that a core holds its request, unchanged, from the moment it raises `req_valid` until `resp_done`, and that it drops the request in the cycle `resp_done` is high. The bench drives each core from one task that sets all request fields at a falling edge and clears `req_valid` at the first falling edge that shows `resp_done`. It raises concurrent requests only in tests where every grant order gives the same final data, and it compares states only after an access whose result does not depend on the order.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_RDX = 2'b01,
    OP_UPG = 2'b10,
    OP_WB  = 2'b11
  } bus_op_e;
endpackage

// File: rtl/mesi_rr_arbiter.sv
module mesi_rr_arbiter #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (grant == '0 && req[idx]) begin
        grant[idx] = 1'b1;
        grant_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (take && req != '0)
      ptr_q <= IW'((int'(grant_idx) + 1) % N);
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R11
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0); // R11
endmodule

// File: rtl/mesi_line_mem.sv
module mesi_line_mem #(
  parameter int LAW    = 4,
  parameter int OFF_BITS = 1,
  parameter int WORD_W = 8,
  localparam int WORDS = 1 << OFF_BITS,
  localparam int LINEW = WORDS * WORD_W,
  localparam int LINES = 1 << LAW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LAW-1:0]   waddr,
  input  logic [LINEW-1:0] wdata,
  input  logic [LAW-1:0]   raddr,
  output logic [LINEW-1:0] rdata
);
  logic [LINEW-1:0] mem [LINES];

  initial begin
    for (int i = 0; i < LINES; i++)
      for (int w = 0; w < WORDS; w++)
        mem[i][w*WORD_W +: WORD_W] = WORD_W'(i * WORDS + w);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mesi_cache_ctl.sv
module mesi_cache_ctl
  import mesi_snoop_pkg::*;
#(
  parameter int SET_BITS = 2,
  parameter int TAG_BITS = 2,
  parameter int OFF_BITS = 1,
  parameter int WORD_W   = 8,
  localparam int AW    = TAG_BITS + SET_BITS + OFF_BITS,
  localparam int LAW   = TAG_BITS + SET_BITS,
  localparam int LINEW = WORD_W << OFF_BITS,
  localparam int SETS  = 1 << SET_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_done,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              bus_req,
  output bus_op_e           bus_op,
  output logic [LAW-1:0]    bus_addr,
  output logic [LINEW-1:0]  bus_wline,
  output logic              bus_wlive,
  input  logic              bus_done,
  input  logic              bus_shared,
  input  logic [LINEW-1:0]  bus_fill,
  input  logic              snp_valid,
  input  bus_op_e           snp_op,
  input  logic [LAW-1:0]    snp_addr,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic [LINEW-1:0]  snp_line,
  input  logic [LAW-1:0]    prb_addr,
  output logic [1:0]        prb_state
);
  typedef enum logic [1:0] {C_IDLE, C_BUS, C_WAIT} cst_e;

  mesi_e              st_q   [SETS];
  logic [TAG_BITS-1:0] tag_q [SETS];
  logic [LINEW-1:0]   line_q [SETS];
  cst_e               cst;
  bus_op_e            bop_q;
  logic [LAW-1:0]     baddr_q;

  logic [SET_BITS-1:0] r_set, b_set, s_set, p_set;
  logic [TAG_BITS-1:0] r_tag, b_tag, s_tag, p_tag;
  logic [OFF_BITS-1:0] r_off;
  mesi_e               r_st;
  logic                r_hit, accept, local_done;

  always_comb begin
    r_set = req_addr[OFF_BITS +: SET_BITS];
    r_tag = req_addr[AW-1 -: TAG_BITS];
    r_off = req_addr[OFF_BITS-1:0];
    b_set = baddr_q[SET_BITS-1:0];
    b_tag = baddr_q[LAW-1 -: TAG_BITS];
    s_set = snp_addr[SET_BITS-1:0];
    s_tag = snp_addr[LAW-1 -: TAG_BITS];
    p_set = prb_addr[SET_BITS-1:0];
    p_tag = prb_addr[LAW-1 -: TAG_BITS];
    r_st  = st_q[r_set];
    r_hit = (r_st != ST_I) && (tag_q[r_set] == r_tag);
    accept = (cst == C_IDLE) && req_valid && !snp_valid;
    local_done = r_hit && ((r_st == ST_M) || (r_st == ST_E) || !req_write);
  end

  assign bus_req   = (cst == C_BUS);
  assign bus_op    = bop_q;
  assign bus_addr  = baddr_q;
  assign bus_wline = line_q[b_set];
  assign bus_wlive = (st_q[b_set] == ST_M) && (tag_q[b_set] == b_tag);
  assign snp_hit   = snp_valid && (st_q[s_set] != ST_I) && (tag_q[s_set] == s_tag);
  assign snp_dirty = snp_hit && (st_q[s_set] == ST_M);
  assign snp_line  = line_q[s_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      cst        <= C_IDLE;
      resp_done  <= 1'b0;
      resp_rdata <= '0;
      bop_q      <= OP_RD;
      baddr_q    <= '0;
      prb_state  <= ST_I;
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
    end else begin
      resp_done <= 1'b0;
      prb_state <= (tag_q[p_set] == p_tag) ? st_q[p_set] : ST_I;
      if (snp_hit)
        st_q[s_set] <= (snp_op == OP_RD) ? ST_S : ST_I;
      case (cst)
        C_IDLE: if (accept) begin
          if (local_done) begin
            resp_done  <= 1'b1;
            resp_rdata <= line_q[r_set][r_off*WORD_W +: WORD_W];
            if (req_write) st_q[r_set] <= ST_M;
            cst <= C_WAIT;
          end else begin
            if (r_hit) begin
              bop_q   <= OP_UPG;
              baddr_q <= {r_tag, r_set};
            end else if (r_st == ST_M) begin
              bop_q   <= OP_WB;
              baddr_q <= {tag_q[r_set], r_set};
            end else begin
              bop_q   <= req_write ? OP_RDX : OP_RD;
              baddr_q <= {r_tag, r_set};
            end
            cst <= C_BUS;
          end
        end
        C_BUS: if (bus_done) begin
          case (bop_q)
            OP_WB:  st_q[b_set] <= ST_I;
            OP_RD:  st_q[b_set] <= bus_shared ? ST_S : ST_E;
            OP_RDX: st_q[b_set] <= ST_M;
            default: if (st_q[b_set] == ST_S && tag_q[b_set] == b_tag) st_q[b_set] <= ST_M;
          endcase
          cst <= C_IDLE;
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && local_done && req_write)
      line_q[r_set][r_off*WORD_W +: WORD_W] <= req_wdata;
    if (cst == C_BUS && bus_done && (bop_q == OP_RD || bop_q == OP_RDX)) begin
      tag_q[b_set]  <= b_tag;
      line_q[b_set] <= bus_fill;
    end
  end

  AST_OWNED_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && r_hit && (r_st == ST_E || r_st == ST_M)) |=> (resp_done && !bus_req)); // R3
  AST_NO_SNOOP_ON_SELF: assert property (@(posedge clk) disable iff (rst)
    bus_done |-> !snp_valid); // R11
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_snoop_pkg::*;
#(
  parameter int NCORES   = 2,
  parameter int SET_BITS = 2,
  parameter int TAG_BITS = 2,
  parameter int OFF_BITS = 1,
  parameter int WORD_W   = 8,
  localparam int AW    = TAG_BITS + SET_BITS + OFF_BITS,
  localparam int LAW   = TAG_BITS + SET_BITS,
  localparam int LINEW = WORD_W << OFF_BITS,
  localparam int IW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCORES-1:0]        req_valid,
  input  logic [NCORES-1:0]        req_write,
  input  logic [NCORES*AW-1:0]     req_addr,
  input  logic [NCORES*WORD_W-1:0] req_wdata,
  output logic [NCORES-1:0]        resp_done,
  output logic [NCORES*WORD_W-1:0] resp_rdata,
  input  logic [LAW-1:0]           prb_addr,
  output logic [2*NCORES-1:0]      prb_state
);
  typedef enum logic [1:0] {B_IDLE, B_SNOOP, B_MEM, B_DONE} bst_e;

  logic [NCORES-1:0] c_req, c_wlive, snp_valid, snp_hit, snp_dirty, bus_done, grant;
  bus_op_e           c_op    [NCORES];
  logic [LAW-1:0]    c_addr  [NCORES];
  logic [LINEW-1:0]  c_wline [NCORES];
  logic [LINEW-1:0]  s_line  [NCORES];

  bst_e             bstate;
  logic [IW-1:0]    win_q, arb_idx;
  bus_op_e          op_q;
  logic [LAW-1:0]   addr_q;
  logic             shared_q, dirty_q;
  logic [LINEW-1:0] dline_q, dl, mem_wdata, mem_rdata;
  logic             mem_we, take;

  assign take = (bstate == B_IDLE) && (c_req != '0);

  mesi_rr_arbiter #(.N(NCORES)) u_arb (
    .clk(clk), .rst(rst), .req(c_req), .take(take),
    .grant(grant), .grant_idx(arb_idx)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_cache
    assign snp_valid[g] = (bstate == B_SNOOP) && (op_q != OP_WB) && (win_q != IW'(g));
    assign bus_done[g]  = (bstate == B_DONE) && (win_q == IW'(g));
    mesi_cache_ctl #(
      .SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS), .OFF_BITS(OFF_BITS), .WORD_W(WORD_W)
    ) u_cache (
      .clk(clk), .rst(rst),
      .req_valid(req_valid[g]), .req_write(req_write[g]),
      .req_addr(req_addr[g*AW +: AW]), .req_wdata(req_wdata[g*WORD_W +: WORD_W]),
      .resp_done(resp_done[g]), .resp_rdata(resp_rdata[g*WORD_W +: WORD_W]),
      .bus_req(c_req[g]), .bus_op(c_op[g]), .bus_addr(c_addr[g]),
      .bus_wline(c_wline[g]), .bus_wlive(c_wlive[g]),
      .bus_done(bus_done[g]), .bus_shared(shared_q), .bus_fill(mem_rdata),
      .snp_valid(snp_valid[g]), .snp_op(op_q), .snp_addr(addr_q),
      .snp_hit(snp_hit[g]), .snp_dirty(snp_dirty[g]), .snp_line(s_line[g]),
      .prb_addr(prb_addr), .prb_state(prb_state[2*g +: 2])
    );
  end

  always_comb begin
    dl = '0;
    for (int k = 0; k < NCORES; k++)
      if (snp_dirty[k]) dl = dl | s_line[k];
    mem_we    = 1'b0;
    mem_wdata = dl;
    if (bstate == B_SNOOP) begin
      if (op_q == OP_WB) begin
        mem_we    = c_wlive[win_q];
        mem_wdata = c_wline[win_q];
      end else begin
        mem_we = (snp_dirty != '0);
      end
    end
  end

  mesi_line_mem #(.LAW(LAW), .OFF_BITS(OFF_BITS), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(mem_wdata),
    .raddr(addr_q), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bstate   <= B_IDLE;
      win_q    <= '0;
      op_q     <= OP_RD;
      addr_q   <= '0;
      shared_q <= 1'b0;
      dirty_q  <= 1'b0;
      dline_q  <= '0;
    end else begin
      case (bstate)
        B_IDLE: if (take) begin
          win_q  <= arb_idx;
          op_q   <= c_op[arb_idx];
          addr_q <= c_addr[arb_idx];
          bstate <= B_SNOOP;
        end
        B_SNOOP: begin
          shared_q <= (snp_hit != '0);
          dirty_q  <= (snp_dirty != '0);
          dline_q  <= dl;
          bstate   <= (op_q == OP_RD || op_q == OP_RDX) ? B_MEM : B_DONE;
        end
        B_MEM:   bstate <= B_DONE;
        default: bstate <= B_IDLE;
      endcase
    end
  end

  int own_cnt, val_cnt;
  always_comb begin
    own_cnt = 0;
    val_cnt = 0;
    for (int k = 0; k < NCORES; k++) begin
      if (prb_state[2*k+1]) own_cnt++;
      if (prb_state[2*k +: 2] != 2'b00) val_cnt++;
    end
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    (own_cnt <= 1) && (own_cnt == 0 || val_cnt == 1)); // R9
  AST_DIRTY_SOLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (snp_dirty != '0) |-> (snp_hit == snp_dirty)); // R9
  AST_FLUSH_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (bstate == B_DONE && dirty_q && (op_q == OP_RD || op_q == OP_RDX)) |-> (mem_rdata == dline_q)); // R6
  AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_done)); // R11
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int NC = 2, SB = 2, TB = 2, OB = 1, DW = 8;
  localparam int AW = TB + SB + OB, LAW = TB + SB;
  localparam int NL = 1 << LAW, NWD = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic          rv [NC], rw [NC];
  logic [AW-1:0] ra [NC];
  logic [DW-1:0] rd [NC];
  logic [NC-1:0] req_valid, req_write, resp_done;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata, resp_rdata;
  logic [LAW-1:0]   prb_addr = '0;
  logic [2*NC-1:0]  prb_state;

  always_comb
    for (int k = 0; k < NC; k++) begin
      req_valid[k] = rv[k];
      req_write[k] = rw[k];
      req_addr[k*AW +: AW] = ra[k];
      req_wdata[k*DW +: DW] = rd[k];
    end

  mesi_snoop_ctrl #(.NCORES(NC), .SET_BITS(SB), .TAG_BITS(TB), .OFF_BITS(OB), .WORD_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
    .resp_rdata(resp_rdata), .prb_addr(prb_addr), .prb_state(prb_state)
  );

  int checks = 0, errors = 0;
  logic [1:0] exp_st [NC][NL];
  logic [DW-1:0] gold [NWD];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic own_check();
    int own = 0, val = 0;
    for (int k = 0; k < NC; k++) begin
      if (prb_state[2*k+1]) own++;
      if (prb_state[2*k +: 2] != 2'b00) val++;
    end
    check("R9 single owner", (own <= 1 && (own == 0 || val == 1)) ? 1 : 0, 1);
  endtask

  // reference MESI model: I=0 S=1 E=2 M=3
  function automatic void model(int c, bit w, int addr, logic [DW-1:0] d);
    int line = addr >> OB;
    int any = 0;
    for (int l = 0; l < NL; l++)
      if ((l % (1 << SB)) == (line % (1 << SB)) && l != line) exp_st[c][l] = 2'd0;
    if (!w) begin
      if (exp_st[c][line] == 2'd0) begin
        for (int o = 0; o < NC; o++)
          if (o != c && exp_st[o][line] != 2'd0) begin
            any = 1;
            exp_st[o][line] = 2'd1;
          end
        exp_st[c][line] = any ? 2'd1 : 2'd2;
      end
    end else begin
      for (int o = 0; o < NC; o++) if (o != c) exp_st[o][line] = 2'd0;
      exp_st[c][line] = 2'd3;
      gold[addr] = d;
    end
  endfunction

  task automatic access(int c, bit w, int addr, logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int lat);
    @(negedge clk);
    rv[c] = 1'b1; rw[c] = w; ra[c] = AW'(addr); rd[c] = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      own_check();
    end while (!resp_done[c] && lat < 2000);
    q = resp_rdata[c*DW +: DW];
    rv[c] = 1'b0;
    if (lat >= 2000) check("R11 request completes", 0, 1);
  endtask

  task automatic states(int line, string tag);
    prb_addr = LAW'(line);
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NC; k++) check(tag, int'(prb_state[2*k +: 2]), int'(exp_st[k][line]));
  endtask

  task automatic do_op(int c, bit w, int addr, logic [DW-1:0] d, bit chk, string tag, output int lat);
    logic [DW-1:0] q;
    prb_addr = LAW'(addr >> OB);
    access(c, w, addr, d, q, lat);
    if (!w) check({tag, " load data R7"}, int'(q), int'(gold[addr]));
    model(c, w, addr, d);
    if (chk) states(addr >> OB, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog R11", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    for (int k = 0; k < NC; k++) begin rv[k] = 0; rw[k] = 0; ra[k] = '0; rd[k] = '0; end
    for (int a = 0; a < NWD; a++) gold[a] = DW'(a);
    for (int k = 0; k < NC; k++) for (int l = 0; l < NL; l++) exp_st[k][l] = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: all Invalid after reset
    for (int l = 0; l < NL; l++) states(l, "R1 reset state");

    // two-core trace on line 2
    do_op(0, 0, 4, 8'h00, 1, "R2 read no sharer -> E", lat);
    do_op(0, 1, 4, 8'h5A, 1, "R3 E store -> M", lat);
    check("R3 E store latency", lat, 1);
    do_op(0, 1, 5, 8'h5B, 1, "R3 M store", lat);
    check("R3 M store latency", lat, 1);
    do_op(1, 0, 4, 8'h00, 1, "R6 remote read of M -> S,S", lat);
    do_op(1, 1, 4, 8'hC3, 1, "R4 store in S -> I,M", lat);
    check("R4 shared store takes bus", (lat > 1) ? 1 : 0, 1);
    do_op(0, 1, 5, 8'h77, 1, "R5 store miss RFO -> M,I", lat);
    do_op(0, 0, 4, 8'h00, 1, "R5 merged line", lat);

    // line granularity and snooped read of E
    do_op(0, 0, 8, 8'h00, 1, "R2 fill E", lat);
    do_op(1, 0, 9, 8'h00, 1, "R12 snooped read E -> S", lat);
    do_op(1, 1, 9, 8'h9E, 1, "R8 other word invalidates", lat);
    do_op(0, 0, 8, 8'h00, 1, "R8 reload after invalidate", lat);
    do_op(0, 1, 8, 8'h31, 1, "R12 invalidate S copy", lat);

    // evictions in set 2
    do_op(0, 1, 12, 8'hE7, 1, "R10 dirty line", lat);
    do_op(0, 0, 20, 8'h00, 1, "R10 conflicting fill", lat);
    states(6, "R10 evicted line invalid");
    do_op(1, 0, 12, 8'h00, 1, "R10 written back data", lat);
    do_op(1, 0, 28, 8'h00, 1, "R10 clean drop", lat);
    states(6, "R10 clean evicted invalid");

    // simultaneous requests
    fork
      begin logic [DW-1:0] q0; int l0; access(0, 0, 2, 8'h00, q0, l0); check("R11 concurrent load c0", int'(q0), int'(gold[2])); end
      begin logic [DW-1:0] q1; int l1; access(1, 0, 2, 8'h00, q1, l1); check("R11 concurrent load c1", int'(q1), int'(gold[2])); end
    join
    model(0, 0, 2, 8'h00); model(1, 0, 2, 8'h00);
    states(1, "R11 concurrent loads both S");
    fork
      begin logic [DW-1:0] q0; int l0; access(0, 1, 6, 8'hA1, q0, l0); end
      begin logic [DW-1:0] q1; int l1; access(1, 1, 7, 8'hB2, q1, l1); end
    join
    model(0, 1, 6, 8'hA1); model(1, 1, 7, 8'hB2);
    do_op(0, 0, 7, 8'h00, 0, "R11 concurrent stores c0 sees c1", lat);
    do_op(1, 0, 6, 8'h00, 0, "R11 concurrent stores c1 sees c0", lat);
    do_op(0, 1, 6, 8'hA5, 1, "R11 resync store", lat);

    // sweep of mixed accesses over every address
    for (int i = 0; i < 400; i++) begin
      int c = ((i / 2) % 2) ^ ((i % 5 == 0) ? 1 : 0);
      int a = (i * 11 + i / 7) % NWD;
      bit w = (i % 3 == 0);
      logic [1:0] pre = exp_st[c][a >> OB];
      do_op(c, w, a, DW'(i * 29 + 7), 1, "R9 sweep", lat);
      if (w && pre[1]) check("R3 sweep owned store latency", lat, 1);
    end
    for (int a = 0; a < NWD; a++) do_op(a % NC, 0, a, 8'h00, 1, "R7 final readback", lat);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule